// File: doc/BRIEF.md
# Iterative Shift-Add Integer Square Root

This block computes the square root of an unsigned operand by settling one bit of the root per clock cycle, starting at the most significant bit. Alongside the partial root it keeps the square of that partial root. Each trial square is therefore built from the previous square plus two shifted terms, and the datapath needs only adders, shifters and one magnitude comparator, with no multiplier.

A caller presents an operand and pulses `in_valid` while the unit is idle. After M working cycles the unit raises `out_valid` for one cycle with the root on `root`. The root then holds until the next computation completes.

The parameter M sets how many result bits are produced. With M = N/2 the result is the integer root. With a larger M the operand is pre-shifted left by 2M-N bits, and the result carries M-N/2 fractional bits.

Top module: `isqrt_shift_add`

## Requirements
- R1: After reset, `out_valid` is 0 and `root` is 0.
- R2: With M = N/2, the result is the largest r such that r*r does not exceed the operand (for N = 8, operand 26 gives 5). The running square never exceeds the shifted operand.
- R3: `out_valid` rises in the M-th cycle after the clock edge that accepts `in_valid`, and it stays high for exactly one cycle.
- R4: `root` holds its value from one completion until the next completion.
- R5: An `in_valid` pulse that arrives while a computation is running is ignored, and the running result is unaffected.
- R6: An operand of 0 gives a root of 0.
- R7: The all-ones operand gives the largest root whose square does not exceed it (for N = 8 and M = 4, operand 255 gives 15).
- R8: With M > N/2, the result is the integer root of the operand shifted left by 2M-N bits. It reads as a fixed-point value with M-N/2 fraction bits (for N = 8, M = 6, operand 42 gives 25, which reads as 6.25).
- R9: The trial-bit register holds a single 1 in its top position at the start of a computation, and it is one-hot or zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Loads the operand and starts a computation when idle |
| operand | input | N | Unsigned operand |
| root | output | M | Root, registered, held between completions |
| out_valid | output | 1 | One-cycle pulse marking a new root |

## Verification
The hardest case to reach from the ports is a new `in_valid` that lands in the middle of a running computation. The bench starts a computation on 26 and, two cycles later, pulses `in_valid` with the all-ones operand. It then checks that the completion arrives at the original latency and carries 5. An exhaustive sweep of all 256 operands in integer mode covers both the zero and the all-ones boundary. A second instance with M = 6 covers the fixed-point result.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } isqrt_state_e;

  function automatic int idx_width(input int steps);
    return (steps > 1) ? $clog2(steps) : 1;
  endfunction
endpackage

// File: rtl/isqrt_weight_shreg.sv
module isqrt_weight_shreg #(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  output logic [M-1:0] weight_o
);
  localparam logic [M-1:0] TOP_ONE = {1'b1, {(M-1){1'b0}}};

  logic [M-1:0] w_q;

  always_ff @(posedge clk) begin
    if (rst)         w_q <= '0;
    else if (load_i) w_q <= TOP_ONE;
    else if (step_i) w_q <= {1'b0, w_q[M-1:1]};
  end

  assign weight_o = w_q;

  // R9: the trial-bit register is one-hot or empty at all times
  p_weight_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(w_q));

  // R9: a load leaves a single 1 in the top position
  p_weight_load_r9: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (w_q == TOP_ONE));
endmodule

// File: rtl/isqrt_step_counter.sv
module isqrt_step_counter #(
  parameter int M  = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  output logic [CW-1:0] idx_o,
  output logic          last_o
);
  localparam logic [CW-1:0] IDX_TOP = CW'(M - 1);

  logic [CW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst)                           idx_q <= '0;
    else if (load_i)                   idx_q <= IDX_TOP;
    else if (step_i && idx_q != '0)    idx_q <= idx_q - 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == '0);

  // R3: while counting, the index moves down by exactly one per step
  p_idx_down_r3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && idx_q != '0) |=> (idx_q == $past(idx_q) - 1'b1));
endmodule

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
  import isqrt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic out_valid_o
);
  isqrt_state_e st_q, st_d;
  logic         vld_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (in_valid_i) st_d = ST_RUN;
      ST_RUN:  if (last_i)     st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign load_o   = (st_q == ST_IDLE) && in_valid_i;
  assign step_o   = (st_q == ST_RUN);
  assign finish_o = step_o && last_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      vld_q <= finish_o;
    end
  end

  assign out_valid_o = vld_q;

  // R3: the completion flag is a single-cycle pulse
  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q);

  // R3: the final step is followed by the completion flag
  p_finish_flag_r3: assert property (@(posedge clk) disable iff (rst)
    finish_o |=> vld_q);

  // R5: no load is taken while a computation runs
  p_no_load_busy_r5: assert property (@(posedge clk) disable iff (rst)
    step_o |-> !load_o);
endmodule

// File: rtl/isqrt_datapath.sv
module isqrt_datapath #(
  parameter int N  = 8,
  parameter int M  = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          finish_i,
  input  logic [N-1:0]  operand_i,
  input  logic [M-1:0]  weight_i,
  input  logic [CW-1:0] idx_i,
  output logic [M-1:0]  root_o
);
  localparam int W2 = 2 * M;
  localparam int PRE_SHIFT = W2 - N;

  logic [W2-1:0] x_ext, x_q, ysq_q, y_wide, term_y, term_sq, trial;
  logic [M-1:0]  y_q, y_next, root_q;
  logic [CW:0]   sh_y, sh_sq;
  logic          take;

  generate
    if (PRE_SHIFT == 0) begin : g_no_pre
      assign x_ext = operand_i;
    end else begin : g_pre
      assign x_ext = {{PRE_SHIFT{1'b0}}, operand_i} << PRE_SHIFT;
    end
  endgenerate

  assign y_wide  = {{M{1'b0}}, y_q};
  assign sh_y    = {1'b0, idx_i} + {{CW{1'b0}}, 1'b1};
  assign sh_sq   = {idx_i, 1'b0};
  assign term_y  = y_wide << sh_y;
  assign term_sq = {{(W2-1){1'b0}}, 1'b1} << sh_sq;
  assign trial   = ysq_q + term_y + term_sq;
  assign take    = (trial <= x_q);
  assign y_next  = take ? (y_q | weight_i) : y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      y_q    <= '0;
      ysq_q  <= '0;
      root_q <= '0;
    end else begin
      if (load_i) begin
        x_q   <= x_ext;
        y_q   <= '0;
        ysq_q <= '0;
      end else if (step_i && take) begin
        y_q   <= y_next;
        ysq_q <= trial;
      end
      if (finish_i) root_q <= y_next;
    end
  end

  assign root_o = root_q;

  // R2: the running square never passes the shifted operand
  p_sq_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    ysq_q <= x_q);

  // R2: the running square only grows during a computation
  p_sq_grows_r2: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> (ysq_q >= $past(ysq_q)));

  // R4: the root changes only on the cycle after a final step
  p_root_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !finish_i |=> $stable(root_q));
endmodule

// File: rtl/isqrt_shift_add.sv
module isqrt_shift_add #(
  parameter int N = 8,
  parameter int M = N / 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [N-1:0] operand,
  output logic [M-1:0] root,
  output logic         out_valid
);
  localparam int CW = isqrt_pkg::idx_width(M);

  logic          load, step, finish, last;
  logic [M-1:0]  weight;
  logic [CW-1:0] idx;

  isqrt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .last_i(last),
    .load_o(load), .step_o(step), .finish_o(finish), .out_valid_o(out_valid)
  );

  isqrt_step_counter #(.M(M), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step),
    .idx_o(idx), .last_o(last)
  );

  isqrt_weight_shreg #(.M(M)) u_wt (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step), .weight_o(weight)
  );

  isqrt_datapath #(.N(N), .M(M), .CW(CW)) u_dp (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step), .finish_i(finish),
    .operand_i(operand), .weight_i(weight), .idx_i(idx), .root_o(root)
  );

  // R9: the trial bit always sits at the position named by the counter
  p_weight_matches_idx_r9: assert property (@(posedge clk) disable iff (rst)
    step |-> (weight == (M'(1) << idx)));
endmodule

// File: tb/isqrt_shift_add_tb_top.sv
module isqrt_shift_add_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int MI = 4;
  localparam int MF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iv_a = 1'b0, iv_b = 1'b0;
  logic [N-1:0] op_a = '0, op_b = '0;
  logic [MI-1:0] root_a;
  logic [MF-1:0] root_b;
  logic ov_a, ov_b;
  int checks = 0, fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isqrt_shift_add #(.N(N), .M(MI)) dut_i (
    .clk(clk), .rst(rst), .in_valid(iv_a), .operand(op_a),
    .root(root_a), .out_valid(ov_a));

  isqrt_shift_add #(.N(N), .M(MF)) dut_frac_i (
    .clk(clk), .rst(rst), .in_valid(iv_b), .operand(op_b),
    .root(root_b), .out_valid(ov_b));

  function automatic longint ref_root(input longint v);
    longint r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      summary();
    end
  end

  // Run one computation on the integer instance; checks latency, pulse, hold
  task automatic run_int(input logic [N-1:0] x, input string req, input bit intrude);
    int c = 0;
    logic [MI-1:0] got;
    @(negedge clk); iv_a = 1'b1; op_a = x;
    @(negedge clk); iv_a = 1'b0;
    while (c < MI + 3) begin
      @(negedge clk); c++;
      if (intrude && c == 2) begin iv_a = 1'b1; op_a = '1; end
      else iv_a = 1'b0;
      if (ov_a) break;
    end
    iv_a = 1'b0;
    check({req, " R3 latency"}, c, MI);
    got = root_a;
    check(req, got, ref_root(x));
    @(negedge clk);
    check("R3 pulse width", ov_a, 0);
    check("R4 hold", root_a, got);
  endtask

  task automatic run_frac(input logic [N-1:0] x, input longint exp);
    int c = 0;
    @(negedge clk); iv_b = 1'b1; op_b = x;
    @(negedge clk); iv_b = 1'b0;
    while (c < MF + 3) begin
      @(negedge clk); c++;
      if (ov_b) break;
    end
    check("R8 latency", c, MF);
    check("R8 value", root_b, exp);
  endtask

  task automatic t_reset();
    check("R1 out_valid", ov_a, 0);
    check("R1 root", root_a, 0);
    check("R1 frac root", root_b, 0);
  endtask

  task automatic t_examples();
    run_int(8'd26, "R2 operand 26", 1'b0);
    run_int(8'd0, "R6 zero", 1'b0);
    run_int(8'hFF, "R7 all ones", 1'b0);
    check("R7 all ones value", root_a, 15);
  endtask

  task automatic t_intrude();
    run_int(8'd26, "R5 ignored start", 1'b1);
    check("R5 root kept", root_a, 5);
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 256; v++) run_int(N'(v), "R2 sweep", 1'b0);
  endtask

  task automatic t_frac();
    run_frac(8'd42, 25);
    run_frac(8'd0, 0);
    run_frac(8'hFF, ref_root(longint'(255) << (2*MF - N)));
    for (int v = 1; v < 256; v += 17)
      run_frac(N'(v), ref_root(longint'(v) << (2*MF - N)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_examples();
    t_intrude();
    t_sweep();
    t_frac();
    summary();
  end
endmodule